// File: doc/BRIEF.md
# Coded-Prescaler Pulse-Width Modulator

This block turns a single reference clock (nominally 24 MHz) into a pulse-width modulated output. A 4-bit code picks the clock divisor from a fixed, sparse set. The divided clock is a stream of single-cycle ticks, and those ticks advance a period counter. The output sits at its active level for the first `duty` ticks of each period of `period` ticks. Some codes are reserved and stop the ticks altogether. One code bypasses the divider, so the output runs at the full reference rate.

Software drives the block through a plain write port with two registers. The control register holds the divider code, a tick-gate bit, an enable bit and a polarity bit. The timing register holds the period count and the duty count. The divider code can only be replaced while the gate is cleared, so a safe divisor change is three writes: clear the gate, write the new code, set the gate again. A new period or duty value is held in a shadow copy and becomes active only when the current period ends, so a change never produces a truncated or stretched pulse.

Top module: `pwm_coded_div`

## Requirements
- R1: After reset both registers read as zero, no ticks are produced, and `pwm_out` is 1 (the inactive level while the polarity bit is 0).
- R2: Divider codes 0 to 4 give divisors 120, 180, 240, 360 and 480. Codes 8 to 12 give 12000, 24000, 36000, 48000 and 72000. Code 15 gives divisor 1. Each period position lasts exactly one divisor of reference cycles.
- R3: Codes 5, 6, 7, 13 and 14 produce no ticks, and the output holds its inactive level.
- R4: A control write replaces the code field only if the stored gate bit (bit 4) is 0 when the write happens. Otherwise the code field of the write is ignored, while the gate, enable and polarity bits are still taken.
- R5: While the gate bit is 0 or the enable bit (bit 5) is 0, no ticks occur and `pwm_out` holds the inactive level from the cycle after the write.
- R6: Polarity bit 6 set to 1 makes the active level high. Polarity bit 6 at 0 makes the active level low.
- R7: With period P and duty d (0 < d < P) and divisor D, the output alternates active runs of d·D cycles with inactive runs of (P−d)·D cycles.
- R8: A duty value at or above the period keeps the output permanently active. A period of 0 keeps it permanently inactive.
- R9: While the channel runs, a timing write becomes active only at the end of the current period. While the channel is stopped, the write becomes active on the next cycle.
- R10: Register layout. Address 0 (control): [3:0] code, [4] gate, [5] enable, [6] polarity. Address 1 (timing): [15:0] period, [31:16] duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 timing |
| wr_data | input | 2*CNT_W | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can fall in the same cycle: a timing write arriving from software, and the end of a period, when the active copy reloads from the shadow. The bench records the output over a window and issues the duty write at eight successive offsets inside an 8-tick period, so one of the writes lands on the reload cycle itself. Every complete active and inactive run inside the window must match either the old duty or the new one. The last complete active run must equal the new duty.

// File: rtl/pwm_coded_pkg.sv
package pwm_coded_pkg;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 17;

  typedef struct packed {
    logic              pol_hi;
    logic              enable;
    logic              gate;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // divisor for a code; zero marks a reserved code
  function automatic logic [DIV_W-1:0] div_of_code(input logic [CODE_W-1:0] c);
    logic [DIV_W-1:0] d;
    case (c)
      4'd0:    d = 17'd120;
      4'd1:    d = 17'd180;
      4'd2:    d = 17'd240;
      4'd3:    d = 17'd360;
      4'd4:    d = 17'd480;
      4'd8:    d = 17'd12000;
      4'd9:    d = 17'd24000;
      4'd10:   d = 17'd36000;
      4'd11:   d = 17'd48000;
      4'd12:   d = 17'd72000;
      4'd15:   d = 17'd1;
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic code_valid(input logic [CODE_W-1:0] c);
    return div_of_code(c) != '0;
  endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_coded_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int WR_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WR_W-1:0]  wr_data,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] duty_q,
  output logic             code_take
);
  ctrl_t wr_ctrl;
  assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
  // code only accepted while the stored gate is off
  assign code_take = wr_en & ~wr_sel & ~ctrl_q.gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        ctrl_q.gate   <= wr_ctrl.gate;
        ctrl_q.enable <= wr_ctrl.enable;
        ctrl_q.pol_hi <= wr_ctrl.pol_hi;
        if (code_take) ctrl_q.code <= wr_ctrl.code;
      end else begin
        period_q <= wr_data[CNT_W-1:0];
        duty_q   <= wr_data[WR_W-1:CNT_W];
      end
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_coded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_on,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              running
);
  logic [DIV_W-1:0] div_w;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign div_w   = div_of_code(code);
  assign running = ch_on & (div_w != '0);
  assign wrap    = (cnt_q == div_w - 1'b1);
  assign tick    = running & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!running) cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             tick,
  input  logic             pol_hi,
  input  logic [CNT_W-1:0] sh_period,
  input  logic [CNT_W-1:0] sh_duty,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output logic             period_end,
  output logic             pwm_out
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W:0]   pos_nx;
  logic             last;
  logic             active;

  assign pos_nx     = {1'b0, pos_q} + 1'b1;
  assign last       = ({1'b0, act_period} <= pos_nx);
  assign period_end = running & tick & last;
  assign active     = running & (act_period != '0) & (pos_q < act_duty);
  assign pwm_out    = pol_hi ? active : ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      act_period <= '0;
      act_duty   <= '0;
    end else if (!running) begin
      pos_q      <= '0;
      act_period <= sh_period;
      act_duty   <= sh_duty;
    end else if (tick) begin
      if (last) begin
        pos_q      <= '0;
        act_period <= sh_period;
        act_duty   <= sh_duty;
      end else begin
        pos_q <= pos_nx[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pwm_coded_div.sv
module pwm_coded_div
  import pwm_coded_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [2*CNT_W-1:0] wr_data,
  output logic               pwm_out
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q, duty_q;
  logic [CNT_W-1:0] act_period, act_duty;
  logic             code_take_w;
  logic             tick_w;
  logic             running_w;
  logic             period_end_w;

  pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_q),
    .period_q  (period_q),
    .duty_q    (duty_q),
    .code_take (code_take_w)
  );

  pwm_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_on   (ctrl_q.enable & ctrl_q.gate),
    .code    (ctrl_q.code),
    .tick    (tick_w),
    .running (running_w)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running_w),
    .tick       (tick_w),
    .pol_hi     (ctrl_q.pol_hi),
    .sh_period  (period_q),
    .sh_duty    (duty_q),
    .act_period (act_period),
    .act_duty   (act_duty),
    .period_end (period_end_w),
    .pwm_out    (pwm_out)
  );
endmodule

// File: rtl/pwm_coded_div_chk.sv
module pwm_coded_div_chk
  import pwm_coded_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              running,
  input logic              gate,
  input logic              enable,
  input logic              pol_hi,
  input logic [CODE_W-1:0] code,
  input logic [CNT_W-1:0]  act_period,
  input logic [CNT_W-1:0]  act_duty,
  input logic              period_end,
  input logic              pwm_out
);
  p_gate_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !tick);

  p_bad_code_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid(code) |-> !tick);

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (pwm_out == !pol_hi));

  p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> $stable(code));

  p_latch_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> ($stable(act_period) && $stable(act_duty)));

  p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && act_period != '0 && act_duty >= act_period) |-> (pwm_out == pol_hi));

  p_zero_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_period == '0) |-> (pwm_out == !pol_hi));
endmodule

bind pwm_coded_div pwm_coded_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .running    (running_w),
  .gate       (ctrl_q.gate),
  .enable     (ctrl_q.enable),
  .pol_hi     (ctrl_q.pol_hi),
  .code       (ctrl_q.code),
  .act_period (act_period),
  .act_duty   (act_duty),
  .period_end (period_end_w),
  .pwm_out    (pwm_out)
);

// File: tb/test_pwm_coded_div.sv
`timescale 1ns/1ps
module test_pwm_coded_div;
  localparam int LIM   = 100000;
  localparam int WD_NS = 760000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cur_code = 0;
  logic rec_on = 1'b0;
  int   rec_n = 0;
  logic rec [64];

  always #2 clk = ~clk;

  pwm_coded_div i_pwm_coded_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always @(negedge clk) begin
    if (rec_on && rec_n < 64) begin
      rec[rec_n] = pwm_out;
      rec_n = rec_n + 1;
    end
  end

  initial begin
    #(WD_NS);
    errors = errors + 1;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // divisor restated as base times multiplier
  function automatic int exp_div(input int c);
    int lo [5];
    int hi [5];
    lo = '{2, 3, 4, 6, 8};
    hi = '{1, 2, 3, 4, 6};
    if (c >= 0 && c <= 4) return 60 * lo[c];
    if (c >= 8 && c <= 12) return 12000 * hi[c-8];
    if (c == 15) return 1;
    return 0;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input int code, input bit gate, input bit en, input bit hi);
    wr(1'b0, {25'd0, hi, en, gate, 4'(code)});
  endtask

  task automatic set_timing(input int p, input int d);
    wr(1'b1, {16'(d), 16'(p)});
  endtask

  task automatic set_div(input int c);
    set_ctrl(cur_code, 1'b0, 1'b1, 1'b1);
    set_ctrl(c, 1'b0, 1'b1, 1'b1);
    set_ctrl(c, 1'b1, 1'b1, 1'b1);
    cur_code = c;
  endtask

  task automatic get_runs(input logic lvl, output int a_len, output int i_len);
    int n;
    n = 0;
    while (pwm_out == lvl && n < LIM) begin @(negedge clk); n++; end
    n = 0;
    while (pwm_out != lvl && n < LIM) begin @(negedge clk); n++; end
    a_len = 0;
    while (pwm_out == lvl && a_len < LIM) begin @(negedge clk); a_len++; end
    i_len = 0;
    while (pwm_out != lvl && i_len < LIM) begin @(negedge clk); i_len++; end
  endtask

  task automatic count_lvl(input logic lvl, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out == lvl) c++;
    end
  endtask

  task automatic runs_check(input string req, input int c, input int p, input int d);
    int a, i, dv;
    dv = exp_div(c);
    get_runs(1'b1, a, i);
    check_eq(req, $sformatf("active run code %0d P %0d d %0d", c, p, d), a, d * dv);
    check_eq(req, $sformatf("idle run code %0d P %0d d %0d", c, p, d), i, (p - d) * dv);
  endtask

  // R9: complete runs in the record must match old or new duty, last active = new
  task automatic analyze_r9(input int oldd, input int newd);
    int s, bad, last_a;
    logic v;
    bad = 0; last_a = -1; s = 0;
    while (s < 64) begin
      int e;
      v = rec[s];
      e = s;
      while (e + 1 < 64 && rec[e+1] == v) e++;
      if (s > 0 && e < 63) begin
        if (v) begin
          if ((e - s + 1) != oldd && (e - s + 1) != newd) bad++;
          last_a = e - s + 1;
        end else begin
          if ((e - s + 1) != 8 - oldd && (e - s + 1) != 8 - newd) bad++;
        end
      end
      s = e + 1;
    end
    check_eq("R9", "glitched runs around timing write", bad, 0);
    check_eq("R9", "last active run after write", last_a, newd);
  endtask

  initial begin
    int a, i, c;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "pwm_out after reset", int'(pwm_out), 1);
    count_lvl(1'b0, 50, c);
    check_eq("R1", "active samples idle after reset", c, 0);

    // R7 R10: bypass code, active high
    set_timing(4, 1);
    set_ctrl(15, 1'b1, 1'b1, 1'b1);
    cur_code = 15;
    get_runs(1'b1, a, i);
    check_eq("R7", "active run P4 d1 div1 (R10 layout)", a, 1);
    check_eq("R7", "idle run P4 d1 div1", i, 3);

    // R6: active low
    set_ctrl(15, 1'b1, 1'b1, 1'b0);
    get_runs(1'b0, a, i);
    check_eq("R6", "low-active run length", a, 1);
    check_eq("R6", "high idle run length", i, 3);

    // R8: full duty and zero period
    set_timing(4, 5);
    repeat (10) @(negedge clk);
    count_lvl(1'b0, 40, c);
    check_eq("R8", "duty above period always active", c, 40);
    set_timing(0, 1);
    repeat (10) @(negedge clk);
    count_lvl(1'b0, 40, c);
    check_eq("R8", "zero period never active", c, 0);

    // R5: disable and gate
    set_timing(4, 2);
    set_ctrl(15, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    set_ctrl(15, 1'b1, 1'b0, 1'b1);
    check_eq("R5", "pwm_out right after disable", int'(pwm_out), 0);
    count_lvl(1'b1, 30, c);
    check_eq("R5", "active samples while disabled", c, 0);
    set_ctrl(15, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    set_ctrl(15, 1'b0, 1'b1, 1'b1);
    count_lvl(1'b1, 30, c);
    check_eq("R5", "active samples while gated", c, 0);

    // R3: reserved codes
    set_ctrl(5, 1'b0, 1'b1, 1'b1);
    set_ctrl(5, 1'b1, 1'b1, 1'b1);
    cur_code = 5;
    count_lvl(1'b1, 2000, c);
    check_eq("R3", "active samples with code 5", c, 0);
    set_div(13);
    count_lvl(1'b1, 2000, c);
    check_eq("R3", "active samples with code 13", c, 0);

    // R4: code ignored while gate set, accepted through sequence
    set_ctrl(cur_code, 1'b0, 1'b1, 1'b1);
    set_timing(2, 1);
    set_div(0);
    runs_check("R2", 0, 2, 1);
    set_ctrl(3, 1'b1, 1'b1, 1'b1);
    runs_check("R4", 0, 2, 1);
    set_div(3);
    runs_check("R4", 3, 2, 1);

    // R2: slow group
    set_div(8);
    runs_check("R2", 8, 2, 1);

    // R2 R7: random mix of fast codes
    for (int t = 0; t < 6; t++) begin
      int codes [6];
      int cd, p, d;
      codes = '{0, 1, 2, 3, 4, 15};
      cd = codes[$urandom_range(0, 5)];
      p  = int'($urandom_range(2, 5));
      d  = int'($urandom_range(1, p - 1));
      set_ctrl(cur_code, 1'b0, 1'b1, 1'b1);
      set_timing(p, d);
      set_div(cd);
      runs_check("R2", cd, p, d);
    end

    // R9: timing write at every offset of an 8-tick period
    set_ctrl(cur_code, 1'b0, 1'b1, 1'b1);
    set_timing(8, 2);
    set_div(15);
    for (int k = 0; k < 8; k++) begin
      int od, nd;
      od = (k % 2 == 0) ? 2 : 6;
      nd = (k % 2 == 0) ? 6 : 2;
      rec_n = 0;
      rec_on = 1'b1;
      repeat (8 + k) @(negedge clk);
      set_timing(8, nd);
      while (rec_n < 64) @(negedge clk);
      rec_on = 1'b0;
      analyze_r9(od, nd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule